// File: doc/BRIEF.md
# Vertical Register Discharge Sequencer

This block clears unwanted charge out of an image sensor's vertical shift register by running fast transfer bursts on its three vertical clock phases. A request comes from one of two places. The first is a low-going level on the active-low discharge input, which is sampled once per line at a fixed tick after line sync. The second is a one-cycle strobe from the trigger controller. Once a request is taken, the sequencer waits for the next line sync. It then emits back-to-back transfer units of a fixed length, and each unit moves one line.

A run started by the discharge input lasts until a release (a rising edge seen at the same sample point) is detected. The unit in progress when the release is seen always completes, and no further unit follows. A run started by the trigger strobe emits a fixed number of units and ignores the discharge input. Every completed unit, and every normal line transfer reported by the surrounding timing logic, is added to a line tally. A readout pulse clears the tally. When the tally reaches its ceiling, an overflow flag is set and bursts are blocked until the next readout pulse.

The controller has five states:
- IDLE: no run and no pending request.
- ARMED: a request has been taken and the block waits for line sync.
- RUN: units are being emitted.
- FINAL: a release has been seen and the current unit is being completed.
- HALT: the tally is at its ceiling.

The transitions are:
- request: IDLE to ARMED.
- go: ARMED to RUN, on line sync.
- next_unit: RUN to RUN, at a unit boundary.
- release: RUN to FINAL, in mid-unit.
- stop: RUN or FINAL to IDLE, at a unit boundary.
- cap: any of IDLE, ARMED, RUN or FINAL to HALT, on the ceiling; RUN and FINAL take it only at a unit boundary.
- recover: HALT to IDLE, on a readout pulse.

Top module: `vdis_sequencer`

## Requirements
- R1: While reset is asserted and right after it, all three phases and `discharging` are 0, `line_count` is 0, `overflow` is 0 and `readout_block` is 0.
- R2: `dis_req_n` is sampled once per line, SAMPLE_TICK+1 clock edges after the edge that captures `line_sync`. `readout_block` is 1 exactly while the last sampled value is 0.
- R3: A falling edge of the sampled level (sampled 1, then 0) seen in IDLE arms the block. `discharging` rises on the edge that captures the next `line_sync` and never earlier.
- R4: A unit lasts UNIT_TICKS cycles, and units follow each other with no gap. With S = UNIT_TICKS/3 and tick 0 as the first cycle of a unit, phase k (a=0, b=1, c=2) is high for ticks k*S+1 through k*S+S-2. At most one phase is high at a time, the order is a, b, c, and all phases are low outside a run.
- R5: If a release is sampled while the tick before that edge lies in unit n, unit n completes and no unit n+1 starts. A run's length is therefore a whole number of units.
- R6: If the input is low for exactly one sampled line, the run emits exactly one unit.
- R7: A `trig_start` strobe in IDLE arms the block. The run starts at the next line sync and emits exactly TRIG_UNITS units. Releases and falls of the discharge input are ignored during it, and strobes taken while armed or running are ignored.
- R8: `line_count` grows by one per completed unit and by one per cycle with `normal_line` high, and saturates at LINE_LIMIT. `readout_pulse` clears it on the next edge and wins over any increment in the same cycle.
- R9: `overflow` is 1 exactly when `line_count` equals LINE_LIMIT. A unit in progress completes, but no new unit starts and requests are ignored until a readout pulse returns the block to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_sync | input | 1 | One-cycle line sync strobe |
| dis_req_n | input | 1 | Discharge request level, active low |
| trig_start | input | 1 | One-cycle discharge strobe from the trigger controller |
| readout_pulse | input | 1 | Readout-gate event; clears the line tally |
| normal_line | input | 1 | One normal line transfer per high cycle |
| phase_a | output | 1 | Vertical clock phase a |
| phase_b | output | 1 | Vertical clock phase b |
| phase_c | output | 1 | Vertical clock phase c |
| discharging | output | 1 | High during a run (RUN or FINAL) |
| readout_block | output | 1 | High while the sampled request is low; suppresses frame-sync readout |
| line_count | output | clog2(LINE_LIMIT+1) | Lines transferred since the last readout |
| overflow | output | 1 | Tally at ceiling; bursts blocked |

## Verification
A tick counter that drifts shows up within one unit, as a phase pulse of the wrong width or as rising edges of phase a that are not UNIT_TICKS apart. A lost FINAL state or a wrong stop decision gives one extra unit. This is visible at `line_count` and at the fall of `discharging` no later than UNIT_TICKS cycles after the release sample. A wrong tally shows at `line_count` on the edge after a unit completes. A missed HALT appears as bursts continuing past the ceiling.

// File: rtl/vdis_pkg.sv
package vdis_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_RUN   = 3'd2,
        ST_FINAL = 3'd3,
        ST_HALT  = 3'd4
    } vdis_state_e;

    localparam int NUM_PHASES = 3;

endpackage

// File: rtl/vdis_edge_sampler.sv
// Samples the request level once per line at a fixed offset after sync
module vdis_edge_sampler #(
    parameter int SAMPLE_TICK = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sync,
    input  logic dis_n,
    output logic fall_evt,
    output logic rise_evt,
    output logic dis_lvl
);
    localparam int PARK = SAMPLE_TICK + 1;
    localparam int LW   = $clog2(PARK + 1);

    logic [LW-1:0] line_tick;
    logic          samp_now;

    assign samp_now = (line_tick == LW'(SAMPLE_TICK));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_tick <= LW'(PARK);
            dis_lvl   <= 1'b1;
        end else begin
            if (line_sync) begin
                line_tick <= '0;
            end else if (line_tick != LW'(PARK)) begin
                line_tick <= line_tick + 1'b1;
            end
            if (samp_now) begin
                dis_lvl <= dis_n;
            end
        end
    end

    assign fall_evt = samp_now &  dis_lvl & ~dis_n;
    assign rise_evt = samp_now & ~dis_lvl &  dis_n;

endmodule

// File: rtl/vdis_phase_gen.sv
// Non-overlapping three-phase pattern decoded from the unit tick
module vdis_phase_gen #(
    parameter int UNIT_TICKS = 42,
    parameter int TW         = 6
) (
    input  logic          active,
    input  logic [TW-1:0] tick,
    output logic [2:0]    phases
);
    localparam int SLOT = UNIT_TICKS / 3;

    for (genvar k = 0; k < 3; k++) begin : g_phase
        localparam int LO = k * SLOT + 1;
        localparam int HI = k * SLOT + SLOT - 2;
        assign phases[k] = active && (tick >= TW'(LO)) && (tick <= TW'(HI));
    end

endmodule

// File: rtl/vdis_line_tally.sv
// Saturating tally of lines moved since the last readout event
module vdis_line_tally #(
    parameter int LINE_LIMIT = 4096,
    parameter int CW         = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          unit_done,
    input  logic          normal_line,
    output logic [CW-1:0] count,
    output logic          cap_next,
    output logic          overflow
);
    localparam logic [CW:0] LIM_W = (CW + 1)'(LINE_LIMIT);

    logic [CW:0]   sum;
    logic [CW-1:0] nxt;

    always_comb begin
        sum = {1'b0, count} + (CW + 1)'(unit_done) + (CW + 1)'(normal_line);
        if (clr) begin
            nxt = '0;
        end else if (sum >= LIM_W) begin
            nxt = CW'(LINE_LIMIT);
        end else begin
            nxt = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= nxt;
        end
    end

    assign cap_next = (nxt == CW'(LINE_LIMIT));
    assign overflow = (count == CW'(LINE_LIMIT));

endmodule

// File: rtl/vdis_sequencer.sv
module vdis_sequencer #(
    parameter int UNIT_TICKS  = 42,
    parameter int SAMPLE_TICK = 34,
    parameter int LINE_LIMIT  = 4096,
    parameter int TRIG_UNITS  = 104
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              line_sync,
    input  logic                              dis_req_n,
    input  logic                              trig_start,
    input  logic                              readout_pulse,
    input  logic                              normal_line,
    output logic                              phase_a,
    output logic                              phase_b,
    output logic                              phase_c,
    output logic                              discharging,
    output logic                              readout_block,
    output logic [$clog2(LINE_LIMIT+1)-1:0]   line_count,
    output logic                              overflow
);
    import vdis_pkg::*;

    localparam int CW = $clog2(LINE_LIMIT + 1);
    localparam int TW = $clog2(UNIT_TICKS);
    localparam int UW = $clog2(TRIG_UNITS + 1);

    vdis_state_e state, state_nxt;

    logic [TW-1:0] tick;
    logic [UW-1:0] run_units;
    logic          trig_src;
    logic          fall_evt, rise_evt, dis_lvl;
    logic          unit_end, running, last_trig_unit, request;
    logic          cap_next, ovf_now;
    logic [2:0]    ph;

    vdis_edge_sampler #(
        .SAMPLE_TICK(SAMPLE_TICK)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_sync(line_sync),
        .dis_n    (dis_req_n),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .dis_lvl  (dis_lvl)
    );

    vdis_line_tally #(
        .LINE_LIMIT(LINE_LIMIT),
        .CW        (CW)
    ) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (readout_pulse),
        .unit_done  (unit_end),
        .normal_line(normal_line),
        .count      (line_count),
        .cap_next   (cap_next),
        .overflow   (ovf_now)
    );

    vdis_phase_gen #(
        .UNIT_TICKS(UNIT_TICKS),
        .TW        (TW)
    ) u_phase (
        .active(running),
        .tick  (tick),
        .phases(ph)
    );

    assign running        = (state == ST_RUN) || (state == ST_FINAL);
    assign unit_end       = running && (tick == TW'(UNIT_TICKS - 1));
    assign last_trig_unit = trig_src && (run_units == UW'(TRIG_UNITS - 1));
    assign request        = fall_evt || trig_start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Unit tick, run length and request source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick      <= '0;
            run_units <= '0;
            trig_src  <= 1'b0;
        end else begin
            if (state == ST_IDLE && request) begin
                trig_src <= trig_start;
            end
            if (state == ST_ARMED) begin
                tick      <= '0;
                run_units <= '0;
            end else if (running) begin
                if (unit_end) begin
                    tick      <= '0;
                    run_units <= run_units + 1'b1;
                end else begin
                    tick <= tick + 1'b1;
                end
            end
        end
    end

    // Next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ovf_now && !readout_pulse) begin
                    state_nxt = ST_HALT;
                end else if (request) begin
                    state_nxt = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (ovf_now && !readout_pulse) begin
                    state_nxt = ST_HALT;
                end else if (line_sync) begin
                    state_nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (unit_end) begin
                    if (cap_next) begin
                        state_nxt = ST_HALT;
                    end else if ((!trig_src && rise_evt) || last_trig_unit) begin
                        state_nxt = ST_IDLE;
                    end
                end else if (!trig_src && rise_evt) begin
                    state_nxt = ST_FINAL;
                end
            end
            ST_FINAL: begin
                if (unit_end) begin
                    state_nxt = cap_next ? ST_HALT : ST_IDLE;
                end
            end
            ST_HALT: begin
                if (readout_pulse) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        phase_a       = ph[0];
        phase_b       = ph[1];
        phase_c       = ph[2];
        discharging   = running;
        readout_block = ~dis_lvl;
        overflow      = ovf_now;
    end

endmodule

// File: rtl/vdis_sequencer_chk.sv
module vdis_sequencer_chk #(
    parameter int LINE_LIMIT = 4096
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            line_sync,
    input logic                            readout_pulse,
    input logic                            phase_a,
    input logic                            phase_b,
    input logic                            phase_c,
    input logic                            discharging,
    input logic [$clog2(LINE_LIMIT+1)-1:0] line_count,
    input logic                            overflow
);
    localparam int CW = $clog2(LINE_LIMIT + 1);

    // R4
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phase_a, phase_b, phase_c}));

    // R4
    phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !discharging |-> !(phase_a || phase_b || phase_c));

    // R3
    start_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(discharging) |-> $past(line_sync));

    // R8
    readout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        readout_pulse |=> (line_count == '0));

    // R8
    tally_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_count <= CW'(LINE_LIMIT));

    // R8
    tally_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !readout_pulse |=> (line_count >= $past(line_count)));

    // R9
    overflow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !discharging) |=> !discharging);

endmodule

bind vdis_sequencer vdis_sequencer_chk #(.LINE_LIMIT(LINE_LIMIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_sync    (line_sync),
    .readout_pulse(readout_pulse),
    .phase_a      (phase_a),
    .phase_b      (phase_b),
    .phase_c      (phase_c),
    .discharging  (discharging),
    .line_count   (line_count),
    .overflow     (overflow)
);

// File: tb/vdis_sequencer_test.sv
`timescale 1ns/1ps
module vdis_sequencer_test;
    localparam int UNIT  = 42;
    localparam int SAMP  = 34;
    localparam int LIMIT = 40;
    localparam int TRIGU = 3;
    localparam int LINE  = 64;
    localparam int CW    = $clog2(LIMIT + 1);

    logic clk = 0, rst_n = 0, line_sync = 0, dis_req_n = 1;
    logic trig_start = 0, readout_pulse = 0, normal_line = 0;
    logic phase_a, phase_b, phase_c, discharging, readout_block, overflow;
    logic [CW-1:0] line_count;

    int n_checks = 0, n_err = 0, cyc = 0, units_seen = 0;

    always #2.5 clk = ~clk;

    vdis_sequencer #(
        .UNIT_TICKS(UNIT), .SAMPLE_TICK(SAMP), .LINE_LIMIT(LIMIT), .TRIG_UNITS(TRIGU)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .dis_req_n(dis_req_n),
        .trig_start(trig_start), .readout_pulse(readout_pulse), .normal_line(normal_line),
        .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c),
        .discharging(discharging), .readout_block(readout_block),
        .line_count(line_count), .overflow(overflow)
    );

    task automatic checkeq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Units for a discharge-input run released in the m-th line after start
    function automatic int exp_units(input int m);
        return ((m - 1) * LINE + SAMP) / UNIT + 1;
    endfunction

    // Port monitor: phase order, widths, unit spacing, run length
    logic pa_q = 0, pb_q = 0, pc_q = 0, dq = 0;
    int last_ph = 0, a_rise = -1, a_len = 0, run_len = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (phase_a) a_len++;
            if (!phase_a && pa_q) begin
                checkeq("R4 phase width", a_len, UNIT / 3 - 2);
                a_len = 0;
            end
            if (phase_a && !pa_q) begin
                checkeq("R4 order a", (last_ph == 0 || last_ph == 3) ? 1 : 0, 1);
                if (a_rise >= 0) checkeq("R4 unit spacing", cyc - a_rise, UNIT);
                a_rise  = cyc;
                last_ph = 1;
            end
            if (phase_b && !pb_q) begin checkeq("R4 order b", last_ph, 1); last_ph = 2; end
            if (phase_c && !pc_q) begin checkeq("R4 order c", last_ph, 2); last_ph = 3; units_seen++; end
            if (discharging) run_len++;
            if (!discharging && dq) begin
                checkeq("R5 whole units", run_len % UNIT, 0);
                run_len = 0; last_ph = 0; a_rise = -1;
            end
        end
        pa_q = phase_a; pb_q = phase_b; pc_q = phase_c; dq = discharging;
    end

    task automatic tick1(); @(posedge clk); #1; endtask
    task automatic sync_only(); line_sync = 1; tick1(); line_sync = 0; endtask
    task automatic line_rest(); repeat (LINE - 1) tick1(); endtask
    task automatic line(); sync_only(); line_rest(); endtask
    task automatic pulse_readout(); readout_pulse = 1; tick1(); readout_pulse = 0; endtask
    task automatic pulse_normal(input int n);
        if (n > 0) begin normal_line = 1; repeat (n) tick1(); normal_line = 0; end
    endtask

    task automatic run_dis(input int m, input int exp_u);
        int base;
        base = units_seen;
        dis_req_n = 0;
        sync_only();
        checkeq("R2 level before sample", readout_block, 0);
        line_rest();
        checkeq("R2 low level sampled", readout_block, 1);
        checkeq("R3 idle until sync", discharging, 0);
        for (int i = 1; i <= m; i++) begin
            if (i == m) dis_req_n = 1;
            sync_only();
            if (i == 1) checkeq("R3 start at sync", discharging, 1);
            line_rest();
        end
        repeat (3) line();
        checkeq("R2 released", readout_block, 0);
        checkeq("R5 stopped", discharging, 0);
        checkeq("R5 unit count", units_seen - base, exp_u);
    endtask

    task automatic run_trig();
        int base;
        base = units_seen;
        trig_start = 1; tick1(); trig_start = 0;
        checkeq("R7 armed waits", discharging, 0);
        dis_req_n = 0;
        sync_only();
        checkeq("R7 start at sync", discharging, 1);
        repeat (10) tick1();
        trig_start = 1; tick1(); trig_start = 0;
        repeat (LINE - 12) tick1();
        dis_req_n = 1;
        line();
        line();
        sync_only();
        checkeq("R7 second strobe ignored", discharging, 0);
        line_rest();
        checkeq("R7 fixed unit count", units_seen - base, TRIGU);
    endtask

    initial begin
        int r, m, nrm, expc;
        r = $urandom(32'd52731);
        tick1();
        checkeq("R1 phases in reset", {29'd0, phase_a, phase_b, phase_c}, 0);
        checkeq("R1 discharging in reset", discharging, 0);
        rst_n = 1;
        tick1();
        checkeq("R1 count after reset", line_count, 0);
        checkeq("R1 overflow after reset", overflow, 0);
        checkeq("R1 block after reset", readout_block, 0);
        line();

        // Directed: one sampled low line gives one unit
        run_dis(1, 1);
        checkeq("R6 single unit tally", line_count, 1);
        pulse_readout();
        checkeq("R8 cleared", line_count, 0);

        run_dis(2, exp_units(2));
        checkeq("R8 tally m2", line_count, exp_units(2));

        // Clear wins over increment
        normal_line = 1; readout_pulse = 1; tick1(); normal_line = 0; readout_pulse = 0;
        checkeq("R8 clear wins", line_count, 0);

        run_trig();
        checkeq("R8 tally trig", line_count, TRIGU);

        // Constrained random mix
        for (int it = 0; it < 8; it++) begin
            pulse_readout();
            nrm = $urandom % 4;
            pulse_normal(nrm);
            if ($urandom % 3 == 0) begin
                run_trig();
                expc = nrm + TRIGU;
            end else begin
                m = 1 + $urandom % 3;
                run_dis(m, exp_units(m));
                expc = nrm + exp_units(m);
            end
            checkeq("R8 random tally", line_count, expc);
        end

        // Overflow: cap stops the run after two units
        pulse_readout();
        pulse_normal(LIMIT - 2);
        checkeq("R8 preload", line_count, LIMIT - 2);
        run_dis(3, 2);
        checkeq("R9 count at ceiling", line_count, LIMIT);
        checkeq("R9 overflow set", overflow, 1);
        trig_start = 1; tick1(); trig_start = 0;
        sync_only();
        checkeq("R9 request blocked", discharging, 0);
        line_rest();
        pulse_normal(2);
        checkeq("R8 saturates", line_count, LIMIT);
        pulse_readout();
        checkeq("R9 overflow cleared", overflow, 0);
        checkeq("R9 count cleared", line_count, 0);
        line();
        run_trig();
        checkeq("R9 runs after recovery", line_count, TRIGU);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule